// File: doc/BRIEF.md
# Audio Channel Interrupt Status Combiner

This block merges the interrupt conditions of several audio channels into one combined status word and one interrupt line. Each channel brings in three single-cycle error events (receive overrun, receive timeout, transmit underrun) and four FIFO level conditions. The events are held in sticky bits until software clears them. The level conditions pass straight through. A per-bit enable mask selects which bits may raise the interrupt, and a global enable gates the line itself.

Software reads the masked combined word to find which channels need service. The seven bits of channel n sit at offset 7·n. Sticky bits are cleared through one shared write-one-to-clear port that has one clear bit per channel for each sticky type.

Top module: `irq_status_combiner`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every sticky bit is 0. With all level inputs low, `stat_raw`, `stat_masked` and `irq_out` are then all zero.
- R2: The bits of channel n occupy `stat_raw[7n+6:7n]`. Within a channel: bit 0 is transmit FIFO empty, bit 1 is receive timeout, bit 2 is transmit half-empty, bit 3 is receive half-full, bit 4 is receive overrun, bit 5 is transmit underrun and bit 6 is receive FIFO full.
- R3: An event pulse on channel n sets its sticky bit in the next cycle. The bit then stays set until it is cleared.
- R4: Writing with `clr_wr` high clears the sticky bit in the next cycle when its clear bit is 1. The clear bits are: `clr_data[n]` for overrun, `clr_data[4+n]` for timeout and `clr_data[8+n]` for underrun. In general the clear bit is the bit for channel 0 shifted left by n, within groups of NUM_CH bits.
- R5: When an event and its clear arrive in the same cycle, the sticky bit ends up set.
- R6: The following have no effect on any sticky bit: a 0 in `clr_data`, the spare top bit `clr_data[12]`, and any value of `clr_data` while `clr_wr` is low.
- R7: Level bits follow their inputs in the same cycle, with no storage. A clear write does not affect them.
- R8: `stat_masked` equals `stat_raw` ANDed bit for bit with `ch_irq_en`.
- R9: `irq_out` is high exactly when `irq_glb_en` is high and at least one bit of `stat_masked` is set.
- R10: One write of 0x1fff clears every sticky bit of every channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_glb_en | input | 1 | Global interrupt line enable |
| ev_rx_ovr | input | NUM_CH | Receive overrun event pulse per channel |
| ev_rx_to | input | NUM_CH | Receive timeout event pulse per channel |
| ev_tx_und | input | NUM_CH | Transmit underrun event pulse per channel |
| lv_tx_empty | input | NUM_CH | Transmit FIFO empty level |
| lv_tx_half | input | NUM_CH | Transmit FIFO half-empty level |
| lv_rx_half | input | NUM_CH | Receive FIFO half-full level |
| lv_rx_full | input | NUM_CH | Receive FIFO full level |
| ch_irq_en | input | 7·NUM_CH | Per-bit interrupt enables, same layout as the status |
| clr_wr | input | 1 | Clear-register write strobe |
| clr_data | input | 3·NUM_CH+1 | Write-one-to-clear data |
| stat_raw | output | 7·NUM_CH | Combined status before masking |
| stat_masked | output | 7·NUM_CH | Combined status after masking |
| irq_out | output | 1 | Shared interrupt line |

## Verification
A sticky bit that is wrongly set or lost appears on `stat_raw` one cycle after the event or clear that caused it. If its enable is set, it also appears on `irq_out` in that same cycle. A clear bit routed to the wrong channel or group leaves one bit set and drops another, and the per-cycle comparison against the reference model catches this on the first clear write. A level bit placed at the wrong offset shows up on the first cycle its input differs from its neighbours.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;

    localparam int CH_BITS  = 7;
    localparam int N_STICKY = 3;

    // Clear-register groups, each NUM_CH bits wide
    localparam int GRP_OVR = 0;
    localparam int GRP_RTO = 1;
    localparam int GRP_UND = 2;

    // Per-channel status, bit 0 at the bottom
    typedef struct packed {
        logic rx_full;    // 6
        logic tx_und;     // 5 sticky
        logic rx_ovr;     // 4 sticky
        logic rx_half;    // 3
        logic tx_half;    // 2
        logic rx_to;      // 1 sticky
        logic tx_empty;   // 0
    } ch_stat_t;

    typedef struct packed {
        logic und;
        logic rto;
        logic ovr;
    } sticky_t;

    function automatic int clr_idx(input int grp, input int ch, input int nch);
        return grp * nch + ch;
    endfunction

endpackage

// File: rtl/irq_sticky_ch.sv
module irq_sticky_ch
    import irq_comb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sticky_t  ev,
    input  sticky_t  clr,
    input  logic     tx_empty,
    input  logic     tx_half,
    input  logic     rx_half,
    input  logic     rx_full,
    output ch_stat_t stat
);
    sticky_t held;

    // An event in the same cycle as its clear wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else begin
            held <= ev | (held & ~clr);
        end
    end

    always_comb begin
        stat          = '0;
        stat.tx_empty = tx_empty;
        stat.rx_to    = held.rto;
        stat.tx_half  = tx_half;
        stat.rx_half  = rx_half;
        stat.rx_ovr   = held.ovr;
        stat.tx_und   = held.und;
        stat.rx_full  = rx_full;
    end
endmodule

// File: rtl/irq_mask_or.sv
module irq_mask_or #(
    parameter int W = 28
) (
    input  logic [W-1:0] raw,
    input  logic [W-1:0] en,
    input  logic         glb_en,
    output logic [W-1:0] masked,
    output logic         irq
);
    always_comb begin
        masked = raw & en;
        irq    = glb_en & (|masked);
    end
endmodule

// File: rtl/irq_status_combiner.sv
module irq_status_combiner
    import irq_comb_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          irq_glb_en,
    input  logic [NUM_CH-1:0]             ev_rx_ovr,
    input  logic [NUM_CH-1:0]             ev_rx_to,
    input  logic [NUM_CH-1:0]             ev_tx_und,
    input  logic [NUM_CH-1:0]             lv_tx_empty,
    input  logic [NUM_CH-1:0]             lv_tx_half,
    input  logic [NUM_CH-1:0]             lv_rx_half,
    input  logic [NUM_CH-1:0]             lv_rx_full,
    input  logic [NUM_CH*CH_BITS-1:0]     ch_irq_en,
    input  logic                          clr_wr,
    input  logic [N_STICKY*NUM_CH:0]      clr_data,
    output logic [NUM_CH*CH_BITS-1:0]     stat_raw,
    output logic [NUM_CH*CH_BITS-1:0]     stat_masked,
    output logic                          irq_out
);
    localparam int STAT_W = NUM_CH * CH_BITS;
    localparam int CLR_W  = N_STICKY * NUM_CH + 1;

    logic spare_unused;
    assign spare_unused = clr_data[CLR_W-1];

    ch_stat_t ch_stat [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        sticky_t ev_c;
        sticky_t clr_c;

        always_comb begin
            ev_c.ovr  = ev_rx_ovr[c];
            ev_c.rto  = ev_rx_to[c];
            ev_c.und  = ev_tx_und[c];
            clr_c.ovr = clr_wr & clr_data[clr_idx(GRP_OVR, c, NUM_CH)];
            clr_c.rto = clr_wr & clr_data[clr_idx(GRP_RTO, c, NUM_CH)];
            clr_c.und = clr_wr & clr_data[clr_idx(GRP_UND, c, NUM_CH)];
        end

        irq_sticky_ch u_ch (
            .clk      (clk),
            .rst      (rst),
            .ev       (ev_c),
            .clr      (clr_c),
            .tx_empty (lv_tx_empty[c]),
            .tx_half  (lv_tx_half[c]),
            .rx_half  (lv_rx_half[c]),
            .rx_full  (lv_rx_full[c]),
            .stat     (ch_stat[c])
        );

        assign stat_raw[c*CH_BITS +: CH_BITS] = ch_stat[c];
    end

    irq_mask_or #(.W(STAT_W)) u_mask (
        .raw    (stat_raw),
        .en     (ch_irq_en),
        .glb_en (irq_glb_en),
        .masked (stat_masked),
        .irq    (irq_out)
    );
endmodule

// File: rtl/irq_status_combiner_chk.sv
module irq_status_combiner_chk
    import irq_comb_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      irq_glb_en,
    input logic [NUM_CH-1:0]         ev_rx_ovr,
    input logic [NUM_CH-1:0]         ev_rx_to,
    input logic [NUM_CH-1:0]         ev_tx_und,
    input logic [NUM_CH-1:0]         lv_tx_empty,
    input logic [NUM_CH-1:0]         lv_tx_half,
    input logic [NUM_CH-1:0]         lv_rx_half,
    input logic [NUM_CH-1:0]         lv_rx_full,
    input logic [NUM_CH*CH_BITS-1:0] ch_irq_en,
    input logic                      clr_wr,
    input logic [N_STICKY*NUM_CH:0]  clr_data,
    input logic [NUM_CH*CH_BITS-1:0] stat_raw,
    input logic [NUM_CH*CH_BITS-1:0] stat_masked,
    input logic                      irq_out
);
    always @(negedge clk) begin
        if (!rst) begin
            AST_MASK_AND: assert (stat_masked == (stat_raw & ch_irq_en)); // R8
            AST_IRQ_LINE: assert (irq_out == (irq_glb_en && (stat_masked != '0))); // R9
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        always @(negedge clk) begin
            if (!rst) begin
                AST_LEVEL_PASS: assert (stat_raw[c*CH_BITS+0] == lv_tx_empty[c] &&
                                        stat_raw[c*CH_BITS+2] == lv_tx_half[c]  &&
                                        stat_raw[c*CH_BITS+3] == lv_rx_half[c]  &&
                                        stat_raw[c*CH_BITS+6] == lv_rx_full[c]); // R7
            end
        end

        AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
            ev_rx_ovr[c] |=> stat_raw[c*CH_BITS+4]); // R3
        AST_UND_SET: assert property (@(posedge clk) disable iff (rst)
            ev_tx_und[c] |=> stat_raw[c*CH_BITS+5]); // R3
        AST_RTO_HOLD: assert property (@(posedge clk) disable iff (rst)
            (stat_raw[c*CH_BITS+1] && !(clr_wr && clr_data[NUM_CH+c]))
            |=> stat_raw[c*CH_BITS+1]); // R3
        AST_OVR_CLR: assert property (@(posedge clk) disable iff (rst)
            (clr_wr && clr_data[c] && !ev_rx_ovr[c]) |=> !stat_raw[c*CH_BITS+4]); // R4
        AST_UND_CLR: assert property (@(posedge clk) disable iff (rst)
            (clr_wr && clr_data[2*NUM_CH+c] && !ev_tx_und[c]) |=> !stat_raw[c*CH_BITS+5]); // R4
    end
endmodule

bind irq_status_combiner irq_status_combiner_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/irq_status_combiner_tb.sv
`timescale 1ns/100ps
module irq_status_combiner_tb;
    localparam int NCH = 4;
    localparam int SW  = NCH * 7;
    localparam int CW  = 3 * NCH + 1;

    logic clk = 0;
    logic rst = 1;
    logic irq_glb_en = 0;
    logic [NCH-1:0] ev_rx_ovr = '0, ev_rx_to = '0, ev_tx_und = '0;
    logic [NCH-1:0] lv_tx_empty = '0, lv_tx_half = '0, lv_rx_half = '0, lv_rx_full = '0;
    logic [SW-1:0]  ch_irq_en = '0;
    logic           clr_wr = 0;
    logic [CW-1:0]  clr_data = '0;
    logic [SW-1:0]  stat_raw, stat_masked;
    logic           irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    bit m_ovr [NCH];
    bit m_rto [NCH];
    bit m_und [NCH];

    always #2.5 clk = ~clk;

    irq_status_combiner #(.NUM_CH(NCH)) u_dut (.*);

    function automatic logic [SW-1:0] exp_raw();
        logic [SW-1:0] r = '0;
        for (int c = 0; c < NCH; c++) begin
            r[c*7+0] = lv_tx_empty[c];
            r[c*7+1] = m_rto[c];
            r[c*7+2] = lv_tx_half[c];
            r[c*7+3] = lv_rx_half[c];
            r[c*7+4] = m_ovr[c];
            r[c*7+5] = m_und[c];
            r[c*7+6] = lv_rx_full[c];
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [SW-1:0] got, input logic [SW-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [SW-1:0] er, em;
        er = exp_raw();
        em = er & ch_irq_en;
        chk("R2 stat_raw", stat_raw, er);
        chk("R8 stat_masked", stat_masked, em);
        chk("R9 irq_out", SW'(irq_out), SW'(irq_glb_en && (em != '0)));
    endtask

    task automatic model_update();
        for (int c = 0; c < NCH; c++) begin
            if (rst) begin
                m_ovr[c] = 0; m_rto[c] = 0; m_und[c] = 0;
            end else begin
                m_ovr[c] = ev_rx_ovr[c] | (m_ovr[c] & !(clr_wr & clr_data[c]));
                m_rto[c] = ev_rx_to[c]  | (m_rto[c] & !(clr_wr & clr_data[NCH+c]));
                m_und[c] = ev_tx_und[c] | (m_und[c] & !(clr_wr & clr_data[2*NCH+c]));
            end
        end
    endtask

    // one clock: check current outputs, advance the model, drop pulses
    task automatic tick();
        #0.2;
        if (!rst) compare_all();
        model_update();
        @(negedge clk);
        ev_rx_ovr = '0; ev_rx_to = '0; ev_tx_und = '0;
        clr_wr = 0; clr_data = '0;
        #0.2;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_ovr[c] = 0; m_rto[c] = 0; m_und[c] = 0;
        end
        @(negedge clk);
        repeat (3) tick();
        rst = 0;
        ch_irq_en = '1;
        irq_glb_en = 1;
        #0.2;
        // R1: reset leaves nothing pending
        chk("R1 raw after reset", stat_raw, '0);
        chk("R1 irq after reset", SW'(irq_out), '0);

        // R3: overrun on channel 2 -> bit 18
        ev_rx_ovr[2] = 1;
        tick();
        chk("R3 ovr ch2 set", stat_raw, SW'(1) << 18);
        tick();
        chk("R3 ovr ch2 held", stat_raw, SW'(1) << 18);

        // R6: clr_wr low with all ones, spare bit, wrong bits
        clr_data = '1;
        tick();
        chk("R6 no strobe", stat_raw, SW'(1) << 18);
        clr_wr = 1; clr_data = CW'(1) << 12;
        tick();
        chk("R6 spare bit", stat_raw, SW'(1) << 18);
        clr_wr = 1; clr_data = 13'h0ffb;
        tick();
        chk("R6 other bits", stat_raw, SW'(1) << 18);

        // R4: clear ch2 overrun via bit 2
        clr_wr = 1; clr_data = 13'h0004;
        tick();
        chk("R4 ovr ch2 cleared", stat_raw, '0);

        // R4: timeout ch3 (bit 22) cleared by bit 7; underrun ch1 (bit 12) by bit 9
        ev_rx_to[3] = 1; ev_tx_und[1] = 1;
        tick();
        chk("R3 rto3 und1 set", stat_raw, (SW'(1) << 22) | (SW'(1) << 12));
        clr_wr = 1; clr_data = 13'h0080;
        tick();
        chk("R4 rto ch3 cleared", stat_raw, SW'(1) << 12);
        clr_wr = 1; clr_data = 13'h0200;
        tick();
        chk("R4 und ch1 cleared", stat_raw, '0);

        // R5: event and clear together
        ev_tx_und[0] = 1; clr_wr = 1; clr_data = 13'h0100;
        tick();
        chk("R5 set wins", stat_raw, SW'(1) << 5);

        // R7: levels pass through, clear does not touch them
        lv_rx_full[3] = 1; lv_tx_empty[0] = 1; clr_wr = 1; clr_data = '1;
        #0.2;
        chk("R7 level same cycle", stat_raw, (SW'(1) << 27) | (SW'(1) << 5) | SW'(1));
        tick();
        chk("R7 level survives clear", stat_raw, (SW'(1) << 27) | SW'(1));
        lv_rx_full = '0; lv_tx_empty = '0;

        // R10: 0x1fff clears everything
        ev_rx_ovr = '1; ev_rx_to = '1; ev_tx_und = '1;
        tick();
        chk("R10 all set", stat_raw, {NCH{7'b0110010}});
        clr_wr = 1; clr_data = 13'h1fff;
        tick();
        chk("R10 all cleared", stat_raw, '0);

        // R8 / R9: masking and global gate
        ev_rx_to[1] = 1;
        tick();
        ch_irq_en = ~(SW'(1) << 8);
        #0.2;
        chk("R8 masked off", stat_masked, '0);
        chk("R9 irq low when masked", SW'(irq_out), '0);
        ch_irq_en = '1; irq_glb_en = 0;
        #0.2;
        chk("R9 irq low when global off", SW'(irq_out), '0);
        irq_glb_en = 1;
        #0.2;
        chk("R9 irq high", SW'(irq_out), SW'(1));
        clr_wr = 1; clr_data = 13'h1fff;
        tick();

        // random traffic, compared every cycle
        for (int i = 0; i < 3000; i++) begin
            ev_rx_ovr   = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
            ev_rx_to    = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
            ev_tx_und   = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
            lv_tx_empty = NCH'($urandom);
            lv_tx_half  = NCH'($urandom);
            lv_rx_half  = NCH'($urandom);
            lv_rx_full  = NCH'($urandom);
            clr_wr      = ($urandom % 3) == 0;
            clr_data    = CW'($urandom);
            if ((i % 50) == 0) ch_irq_en = SW'($urandom) & SW'($urandom);
            if ((i % 97) == 0) irq_glb_en = $urandom % 2;
            if (i == 1500) rst = 1;
            if (i == 1503) rst = 0;
            tick();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule